// File: doc/BRIEF.md
# Lattice Swap-Condition Check Unit

This block decides, for one column index of an upper-triangular basis matrix taken through lattice basis reduction, whether the two neighbouring columns must be exchanged. It takes three signed fixed-point entries: the diagonal element of the previous column, the off-diagonal element above the current diagonal, and the current diagonal element. A vectoring CORDIC forms the length of the two-element vector (off-diagonal, current diagonal). That length is compared with a scaled copy of the previous diagonal's magnitude.

The check works on lengths rather than squared norms. The threshold is 0.875 times the previous diagonal, which stands in for the square root of the reduction parameter 0.75. The CORDIC gain is not removed from the length. The gain is folded into the constant on the reference side instead. The length leaves the block with the gain still in it, and it serves as the new diagonal entry when an exchange takes place. The violation flag steers the column-index controller and enables the downstream rotation and swap logic. Those parts are outside this block.

The unit is a two-stage pipeline. It accepts one request per cycle, and each result appears exactly two cycles after its request.

Top module: `swap_chk_unit`

## Requirements
- R1: `valid_o` rises exactly two clock edges after the `valid_i` that launched it, and it stays low for every cycle that no request launched.
- R2: For each request, `mag_o` is within 4 LSB of K·sqrt(off² + diag²). K is the gain of a 12-iteration CORDIC, about 1.64676, and `mag_o` keeps the same integer scale as the inputs.
- R3: The result depends only on the absolute values of the three inputs. Negating any input gives the same `mag_o` and `swap_o`.
- R4: `swap_o` is 1 when K·sqrt(off² + diag²) < 0.875·K·|prev_diag|, and 0 when it is larger. Margins below 6 LSB are left to rounding.
- R5: When `r_prev_diag_i` is 0, `swap_o` is 0.
- R6: When both `r_off_i` and `r_diag_i` are 0 and `r_prev_diag_i` is not 0, `mag_o` is 0 and `swap_o` is 1.
- R7: Full-scale inputs of -32768 on every port produce a correct magnitude without wrap-around. The result lies above 2^16.
- R8: On cycles without a new result, `mag_o` and `swap_o` keep their last values.
- R9: After reset, `valid_o`, `swap_o` and `mag_o` are all 0.
- R10: Requests on back-to-back cycles each yield their own correct result, in order, one per cycle.
- R11: `mag_o` is never smaller than the larger of |off| and |diag|.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Request strobe |
| r_prev_diag_i | input | DATA_W | Signed diagonal entry of the previous column |
| r_off_i | input | DATA_W | Signed entry above the current diagonal |
| r_diag_i | input | DATA_W | Signed diagonal entry of the current column |
| valid_o | output | 1 | Result strobe, two cycles after the request |
| swap_o | output | 1 | Swap condition violated |
| mag_o | output | DATA_W+1 | Vector length including the CORDIC gain |

## Verification
The bench checks a zero off-diagonal and diagonal against a nonzero previous diagonal. A design that reads a zero length as passing would miss the swap there. A zero previous diagonal must never swap, and an inverted or non-strict compare would flag it. Full-scale negative inputs test the absolute value and the datapath width. A one-bit-short datapath would wrap and return a small length. Sign-flipped copies of the same request must give identical outputs, so a design that rotates signed values without taking magnitudes first will disagree. A continuous random stream, with idle gaps between bursts, catches a pipeline that drops, repeats or reorders results, and any output that drifts while no result is due.

// File: rtl/swap_chk_pkg.sv
package swap_chk_pkg;
  localparam int unsigned DATA_W      = 16;
  localparam int unsigned CORDIC_ITER = 12;
  localparam int unsigned GUARD_W     = 3;
  // 0.875 * CORDIC gain (12 iterations) in Q2.14
  localparam int unsigned REF_Q       = 23608;
  localparam int unsigned REF_FRAC    = 14;
  localparam int unsigned REF_W       = 16;
endpackage

// File: rtl/swap_chk_abs.sv
module swap_chk_abs #(
  parameter int unsigned W = 16
) (
  input  logic signed [W-1:0] val_i,
  output logic        [W-1:0] mag_o
);
  // -2^(W-1) maps to 2^(W-1), still representable unsigned
  assign mag_o = val_i[W-1] ? (~val_i + 1'b1) : val_i;
endmodule

// File: rtl/swap_chk_cordic_seg.sv
module swap_chk_cordic_seg #(
  parameter int unsigned IW    = 21,
  parameter int unsigned FIRST = 0,
  parameter int unsigned COUNT = 6
) (
  input  logic signed [IW-1:0] x_i,
  input  logic signed [IW-1:0] y_i,
  output logic signed [IW-1:0] x_o,
  output logic signed [IW-1:0] y_o
);
  logic signed [IW-1:0] xs [COUNT+1];
  logic signed [IW-1:0] ys [COUNT+1];

  assign xs[0] = x_i;
  assign ys[0] = y_i;

  for (genvar j = 0; j < COUNT; j++) begin : g_rot
    localparam int unsigned SH = FIRST + j;
    logic pos;
    assign pos       = ~ys[j][IW-1];
    assign xs[j+1]   = pos ? xs[j] + (ys[j] >>> SH) : xs[j] - (ys[j] >>> SH);
    assign ys[j+1]   = pos ? ys[j] - (xs[j] >>> SH) : ys[j] + (xs[j] >>> SH);
  end

  assign x_o = xs[COUNT];
  assign y_o = ys[COUNT];
endmodule

// File: rtl/swap_chk_cmp.sv
module swap_chk_cmp #(
  parameter int unsigned W        = 16,
  parameter int unsigned IW       = 21,
  parameter int unsigned GW       = 3,
  parameter int unsigned REF_Q    = 23608,
  parameter int unsigned REF_FRAC = 14,
  parameter int unsigned REF_W    = 16
) (
  input  logic [IW-1:0] len_i,
  input  logic [W-1:0]  pabs_i,
  output logic          viol_o
);
  localparam int unsigned CW = IW + REF_FRAC;
  localparam int unsigned PW = W + REF_W;

  logic [PW-1:0] prod;
  logic [CW-1:0] lhs, rhs;

  // both sides carry GW guard bits and REF_FRAC fraction bits: no truncation
  assign prod   = PW'(pabs_i) * PW'(REF_Q);
  assign lhs    = {len_i, {REF_FRAC{1'b0}}};
  assign rhs    = CW'(prod) << GW;
  assign viol_o = lhs < rhs;
endmodule

// File: rtl/swap_chk_unit.sv
module swap_chk_unit
  import swap_chk_pkg::*;
#(
  parameter int unsigned DW    = DATA_W,
  parameter int unsigned ITER  = CORDIC_ITER,
  parameter int unsigned GW    = GUARD_W,
  parameter int unsigned RQ    = REF_Q,
  parameter int unsigned RFRAC = REF_FRAC,
  parameter int unsigned RW    = REF_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [DW-1:0]     r_prev_diag_i,
  input  logic [DW-1:0]     r_off_i,
  input  logic [DW-1:0]     r_diag_i,
  output logic              valid_o,
  output logic              swap_o,
  output logic [DW:0]       mag_o
);
  localparam int unsigned IW    = DW + 2 + GW;
  localparam int unsigned MW    = DW + 1;
  localparam int unsigned N1    = ITER / 2;
  localparam int unsigned N2    = ITER - N1 - 1;
  localparam int unsigned LAST  = ITER - 1;

  // stage 1: magnitudes and first half of micro-rotations
  logic [DW-1:0] off_abs, diag_abs, prev_abs;

  swap_chk_abs #(.W(DW)) u_abs_off  (.val_i(r_off_i),       .mag_o(off_abs));
  swap_chk_abs #(.W(DW)) u_abs_diag (.val_i(r_diag_i),      .mag_o(diag_abs));
  swap_chk_abs #(.W(DW)) u_abs_prev (.val_i(r_prev_diag_i), .mag_o(prev_abs));

  logic signed [IW-1:0] x0, y0, x1, y1;
  assign x0 = {2'b00, off_abs,  {GW{1'b0}}};
  assign y0 = {2'b00, diag_abs, {GW{1'b0}}};

  swap_chk_cordic_seg #(.IW(IW), .FIRST(0), .COUNT(N1)) u_seg_a (
    .x_i(x0), .y_i(y0), .x_o(x1), .y_o(y1)
  );

  logic                 s1_vld;
  logic signed [IW-1:0] s1_x, s1_y;
  logic [DW-1:0]        s1_pabs;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_vld  <= 1'b0;
      s1_x    <= '0;
      s1_y    <= '0;
      s1_pabs <= '0;
    end else begin
      s1_vld <= valid_i;
      if (valid_i) begin
        s1_x    <= x1;
        s1_y    <= y1;
        s1_pabs <= prev_abs;
      end
    end
  end

  // stage 2: remaining rotations, last one on x only, then compare
  logic signed [IW-1:0] x2, y2, x_fin;

  swap_chk_cordic_seg #(.IW(IW), .FIRST(N1), .COUNT(N2)) u_seg_b (
    .x_i(s1_x), .y_i(s1_y), .x_o(x2), .y_o(y2)
  );

  assign x_fin = y2[IW-1] ? x2 - (y2 >>> LAST) : x2 + (y2 >>> LAST);

  logic viol;
  swap_chk_cmp #(
    .W(DW), .IW(IW), .GW(GW), .REF_Q(RQ), .REF_FRAC(RFRAC), .REF_W(RW)
  ) u_cmp (
    .len_i(x_fin), .pabs_i(s1_pabs), .viol_o(viol)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      swap_o  <= 1'b0;
      mag_o   <= '0;
    end else begin
      valid_o <= s1_vld;
      if (s1_vld) begin
        swap_o <= viol;
        mag_o  <= x_fin[GW +: MW];
      end
    end
  end
endmodule

// File: rtl/swap_chk_unit_chk.sv
module swap_chk_unit_chk #(
  parameter int unsigned DW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          valid_i,
  input logic [DW-1:0] r_prev_diag_i,
  input logic [DW-1:0] r_off_i,
  input logic [DW-1:0] r_diag_i,
  input logic          valid_o,
  input logic          swap_o,
  input logic [DW:0]   mag_o
);
  logic [1:0] age;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) age <= '0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  logic [DW-1:0] a_off, a_diag, a_big;
  assign a_off  = r_off_i[DW-1]  ? (~r_off_i + 1'b1)  : r_off_i;
  assign a_diag = r_diag_i[DW-1] ? (~r_diag_i + 1'b1) : r_diag_i;
  assign a_big  = (a_off > a_diag) ? a_off : a_diag;

  logic zero_vec, zero_prev;
  assign zero_vec  = (r_off_i == '0) && (r_diag_i == '0) && (r_prev_diag_i != '0);
  assign zero_prev = (r_prev_diag_i == '0);

  p_latency_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age >= 2'd2) |-> (valid_o == $past(valid_i, 2)));

  p_prev_zero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age >= 2'd2 && valid_o && $past(valid_i && zero_prev, 2)) |-> !swap_o);

  p_zero_vec_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age >= 2'd2 && valid_o && $past(valid_i && zero_vec, 2)) |-> (swap_o && mag_o == '0));

  p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age >= 2'd1 && !valid_o) |-> ($stable(mag_o) && $stable(swap_o)));

  p_floor_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age >= 2'd2 && valid_o && $past(valid_i, 2)) |-> (mag_o >= {1'b0, $past(a_big, 2)}));
endmodule

bind swap_chk_unit swap_chk_unit_chk #(.DW(DW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i),
  .r_prev_diag_i(r_prev_diag_i), .r_off_i(r_off_i), .r_diag_i(r_diag_i),
  .valid_o(valid_o), .swap_o(swap_o), .mag_o(mag_o)
);

// File: tb/sim_swap_chk_unit.sv
`timescale 1ns/1ps
module sim_swap_chk_unit;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic valid_i = 1'b0;
  logic signed [15:0] p_i = '0, o_i = '0, d_i = '0;
  logic valid_o, swap_o;
  logic [16:0] mag_o;

  int total = 0, bad = 0;
  bit d1_v = 0, d2_v = 0;
  int d1_p = 0, d1_o = 0, d1_d = 0, d2_p = 0, d2_o = 0, d2_d = 0;
  int last_mag = 0, prev_mag = 0, held_mag = 0;
  bit last_swap = 0, prev_swap = 0, held_swap = 0;
  real gain;

  always #10 clk = ~clk;

  swap_chk_unit u0 (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i),
    .r_prev_diag_i(p_i), .r_off_i(o_i), .r_diag_i(d_i),
    .valid_o(valid_o), .swap_o(swap_o), .mag_o(mag_o)
  );

  function automatic real ideal_len(int a, int b);
    return gain * $sqrt(real'(longint'(a) * a + longint'(b) * b));
  endfunction

  function automatic int iabs(int a);
    return a < 0 ? -a : a;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic check_out();
    real len, thr, diff;
    chk(valid_o == d2_v, "R1/R10 valid_o", int'(valid_o), int'(d2_v));
    if (d2_v) begin
      len  = ideal_len(d2_o, d2_d);
      thr  = 0.875 * gain * iabs(d2_p);
      diff = real'(mag_o) - len;
      chk(diff <= 4.0 && diff >= -4.0, "R2 mag", int'(mag_o), int'(len));
      if (len - thr >= 6.0 || thr - len >= 6.0)
        chk(swap_o == (len < thr), "R4 swap", int'(swap_o), int'(len < thr));
      if (d2_p == 0) chk(swap_o == 1'b0, "R5 swap", int'(swap_o), 0);
      if (d2_o == 0 && d2_d == 0 && d2_p != 0)
        chk(swap_o && mag_o == 0, "R6 swap/mag", int'(mag_o), 0);
      chk(int'(mag_o) >= iabs(d2_o) && int'(mag_o) >= iabs(d2_d), "R11 floor",
          int'(mag_o), (iabs(d2_o) > iabs(d2_d)) ? iabs(d2_o) : iabs(d2_d));
      prev_mag = last_mag; prev_swap = last_swap;
      last_mag = int'(mag_o); last_swap = swap_o;
      held_mag = int'(mag_o); held_swap = swap_o;
    end else begin
      chk(int'(mag_o) == held_mag && swap_o == held_swap, "R8 hold", int'(mag_o), held_mag);
    end
  endtask

  task automatic step(bit v, int p, int o, int d);
    @(negedge clk);
    check_out();
    d2_v = d1_v; d2_p = d1_p; d2_o = d1_o; d2_d = d1_d;
    d1_v = v; d1_p = p; d1_o = o; d1_d = d;
    valid_i = v;
    p_i = 16'(p); o_i = 16'(o); d_i = 16'(d);
  endtask

  task automatic idle_noise(int n);
    for (int i = 0; i < n; i++)
      step(0, $signed(16'($urandom)), $signed(16'($urandom)), $signed(16'($urandom)));
  endtask

  task automatic sign_pair(int p, int o, int d);
    step(1, p, o, d);
    step(1, -p, -o, d);
    idle_noise(2);
    chk(prev_mag == last_mag && prev_swap == last_swap, "R3 sign", last_mag, prev_mag);
    step(1, p, -o, -d);
    idle_noise(2);
    chk(prev_mag == last_mag && prev_swap == last_swap, "R3 sign", last_mag, prev_mag);
  endtask

  initial begin
    for (int c = 0; c < 200000; c++) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(32'h5eed1234);
    gain = 1.0;
    for (int i = 0; i < 12; i++) gain = gain * $sqrt(1.0 + 1.0 / real'(longint'(1) << (2 * i)));
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(valid_o == 0 && swap_o == 0 && mag_o == 0, "R9 reset", int'(mag_o), 0);
    rst_n = 1'b1;
    idle_noise(2);
    // directed corners
    step(1, 1000, 0, 0);            // R6
    step(1, 0, 300, -200);          // R5
    step(1, 0, 0, 0);               // R5
    step(1, -32768, -32768, -32768); // R7
    step(1, 32767, 100, 50);        // R4 swap expected
    step(1, 100, 32767, 32767);     // R4 no swap
    idle_noise(2);
    chk(last_mag > 65536, "R7 full scale", last_mag, 65537);
    sign_pair(12000, 3000, -4000);
    sign_pair(-500, 20000, 7);
    // random bursts with gaps, R10
    for (int b = 0; b < 300; b++) begin
      int len = 1 + int'($urandom_range(7));
      for (int k = 0; k < len; k++)
        step(1, $signed(16'($urandom)), $signed(16'($urandom)) >>> $urandom_range(8),
             $signed(16'($urandom)) >>> $urandom_range(8));
      idle_noise(int'($urandom_range(3)));
    end
    idle_noise(3);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule